// File: doc/BRIEF.md
# Port-Mapped Peripheral Hub for an 8-bit Soft Processor

This block sits between the port bus of a small 8-bit soft processor and the few peripherals that processor talks to. Each bus cycle carries an 8-bit port number, an 8-bit write byte and separate write and read strobes. The hub decodes the port number into one of several regions:

- a 64-byte scratch RAM the processor can write and read;
- a 64-byte constant table it can only read;
- a shared register that is both an output and an input;
- an output-only register;
- a captured external input byte.

Every other port number reads as zero and ignores writes. The decoder sees only the port number, so the processor gets the same result whether it names the port as a constant or through a register. Reads are registered: the byte appears on the read bus one clock after a read strobe and stays there until the next read strobe.

The hub also holds the processor's interrupt request. An external event pulse sets a latch that drives the processor's interrupt input. The processor's acknowledge clears the latch. If an event arrives in the same cycle as an acknowledge, the latch stays set.

Top module: `pio_port_hub`

## Requirements
- R1: A write strobe with port 0x00–0x3F stores the write byte in scratch RAM at the port's low six bits. A later read of that port returns the byte.
- R2: A read of port 0x40–0x7F returns the port number XOR 0xA5.
- R3: Writes to ports 0x40–0x7F change neither the constant table nor any scratch RAM byte.
- R4: Port 0x80 is one register. A write strobe loads it, `out_shared` shows it, and a read of 0x80 returns it, including on the read right after the write.
- R5: Port 0xC0 is an output-only register shown on `out_reg`. A write strobe loads it, and a read of 0xC0 returns 0x00.
- R6: `ext_data` is captured into a register every clock. A read of port 0xCF returns that captured byte, and a write to 0xCF has no effect.
- R7: Ports 0x81–0xBF, 0xC1–0xCE and 0xD0–0xFF read as 0x00, and writes to them change no register or RAM byte.
- R8: Without a write strobe, no register or RAM byte changes, whatever the port number and write byte.
- R9: `in_port` takes the addressed byte on the clock edge that samples a read strobe, and holds its value while no read strobe is present.
- R10: `irq` goes to 1 on the clock after `ext_event` is high and goes to 0 on the clock after `interrupt_ack` is high. When both are high in the same cycle, `irq` becomes 1.
- R11: A synchronous reset clears `irq`, `in_port`, `out_shared`, `out_reg` and the captured input. RAM contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_id | input | 8 | Port number of the current bus cycle |
| out_port | input | 8 | Byte written by the processor |
| write_strobe | input | 1 | Write strobe |
| read_strobe | input | 1 | Read strobe |
| interrupt_ack | input | 1 | Processor acknowledge; clears the interrupt latch |
| ext_event | input | 1 | External interrupt event |
| ext_data | input | 8 | External byte, readable at port 0xCF |
| in_port | output | 8 | Registered read data |
| out_shared | output | 8 | Register at port 0x80 |
| out_reg | output | 8 | Output-only register at port 0xC0 |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench fills the RAM, writes every table, unmapped and input-only port with marker bytes, and then reads all 256 ports. This sweep exposes a decoder that wraps table or unmapped writes into RAM through the low six address bits, or that leaks a stale register byte onto an unmapped port. Reading 0x80 right after writing it catches a shared register implemented as two separate copies. Reading 0xC0 catches an output register that wrongly echoes onto the read bus. It checks the read bus just before and just after the sampling edge, and after idle cycles, which catches wrong read latency or a read register that updates without a strobe. Asserting event and acknowledge in the same cycle catches a latch where the clear beats the set, which would drop the interrupt.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    RGN_RAM     = 3'd0,
    RGN_TAB     = 3'd1,
    RGN_SHARED  = 3'd2,
    RGN_INCAP   = 3'd3,
    RGN_OUTONLY = 3'd4,
    RGN_NONE    = 3'd5
  } region_e;
endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode
  import pio_pkg::*;
#(
  parameter int AW = 8,
  parameter int MEM_AW = 6,
  parameter logic [AW-1:0] SHARED_ADDR = 8'h80,
  parameter logic [AW-1:0] OUTREG_ADDR = 8'hC0,
  parameter logic [AW-1:0] INCAP_ADDR  = 8'hCF
) (
  input  logic [AW-1:0] port_id,
  input  logic          write_strobe,
  output region_e       region,
  output logic          ram_we,
  output logic          shared_we,
  output logic          outreg_we
);
  localparam int HI_W = AW - MEM_AW;
  localparam logic [HI_W-1:0] RAM_HI = HI_W'(0);
  localparam logic [HI_W-1:0] TAB_HI = HI_W'(1);

  logic [HI_W-1:0] hi;
  assign hi = port_id[AW-1:MEM_AW];

  always_comb begin
    if (hi == RAM_HI)                 region = RGN_RAM;
    else if (hi == TAB_HI)            region = RGN_TAB;
    else if (port_id == SHARED_ADDR)  region = RGN_SHARED;
    else if (port_id == INCAP_ADDR)   region = RGN_INCAP;
    else if (port_id == OUTREG_ADDR)  region = RGN_OUTONLY;
    else                              region = RGN_NONE;
  end

  assign ram_we    = write_strobe && (region == RGN_RAM);
  assign shared_we = write_strobe && (region == RGN_SHARED);
  assign outreg_we = write_strobe && (region == RGN_OUTONLY);

  always_comb begin
    p_one_enable_r8: assert ($countones({ram_we, shared_we, outreg_we}) <= 1)
      else $error("more than one write enable active");
  end
endmodule

// File: rtl/pio_data_ram.sv
module pio_data_ram #(
  parameter int DW = 8,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [MEM_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << MEM_AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/pio_const_table.sv
module pio_const_table #(
  parameter int AW = 8,
  parameter int MEM_AW = 6,
  parameter logic [AW-1:0] TABLE_KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              re,
  input  logic [MEM_AW-1:0] addr,
  output logic [AW-1:0]     rdata
);
  localparam int HI_W = AW - MEM_AW;
  localparam logic [HI_W-1:0] TAB_HI = HI_W'(1);

  function automatic logic [AW-1:0] entry(input logic [MEM_AW-1:0] idx);
    return {TAB_HI, idx} ^ TABLE_KEY;
  endfunction

  always_ff @(posedge clk) begin
    if (re) rdata <= entry(addr);
  end
endmodule

// File: rtl/pio_irq_latch.sv
module pio_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic event_in,
  input  logic ack,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)           irq <= 1'b0;
    else if (event_in) irq <= 1'b1;
    else if (ack)      irq <= 1'b0;
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    event_in |=> irq) else $error("event lost");
  p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (ack && !event_in) |=> !irq) else $error("ack did not clear");
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!ack && !event_in) |=> $stable(irq)) else $error("irq changed spontaneously");
endmodule

// File: rtl/pio_port_hub.sv
module pio_port_hub
  import pio_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int MEM_AW = 6,
  parameter logic [AW-1:0] SHARED_ADDR = 8'h80,
  parameter logic [AW-1:0] OUTREG_ADDR = 8'hC0,
  parameter logic [AW-1:0] INCAP_ADDR  = 8'hCF,
  parameter logic [AW-1:0] TABLE_KEY   = 8'hA5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] port_id,
  input  logic [DW-1:0] out_port,
  input  logic          write_strobe,
  input  logic          read_strobe,
  input  logic          interrupt_ack,
  input  logic          ext_event,
  input  logic [DW-1:0] ext_data,
  output logic [DW-1:0] in_port,
  output logic [DW-1:0] out_shared,
  output logic [DW-1:0] out_reg,
  output logic          irq
);
  region_e       region, sel_q;
  logic          ram_we, shared_we, outreg_we;
  logic [DW-1:0] ram_q, small_q, cap_q;
  logic [AW-1:0] tab_q;

  pio_addr_decode #(
    .AW(AW), .MEM_AW(MEM_AW), .SHARED_ADDR(SHARED_ADDR),
    .OUTREG_ADDR(OUTREG_ADDR), .INCAP_ADDR(INCAP_ADDR)
  ) u_dec (
    .port_id(port_id), .write_strobe(write_strobe), .region(region),
    .ram_we(ram_we), .shared_we(shared_we), .outreg_we(outreg_we)
  );

  pio_data_ram #(.DW(DW), .MEM_AW(MEM_AW)) u_ram (
    .clk(clk), .we(ram_we), .re(read_strobe),
    .addr(port_id[MEM_AW-1:0]), .wdata(out_port), .rdata(ram_q)
  );

  pio_const_table #(.AW(AW), .MEM_AW(MEM_AW), .TABLE_KEY(TABLE_KEY)) u_tab (
    .clk(clk), .re(read_strobe), .addr(port_id[MEM_AW-1:0]), .rdata(tab_q)
  );

  pio_irq_latch u_irq (
    .clk(clk), .rst(rst), .event_in(ext_event), .ack(interrupt_ack), .irq(irq)
  );

  // Output registers and input capture
  always_ff @(posedge clk) begin
    if (rst) begin
      out_shared <= '0;
      out_reg    <= '0;
      cap_q      <= '0;
    end else begin
      cap_q <= ext_data;
      if (shared_we) out_shared <= out_port;
      if (outreg_we) out_reg    <= out_port;
    end
  end

  // Registered read selection; memories carry their own output register
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= RGN_NONE;
      small_q <= '0;
    end else if (read_strobe) begin
      sel_q <= region;
      unique case (region)
        RGN_SHARED: small_q <= out_shared;
        RGN_INCAP:  small_q <= cap_q;
        default:    small_q <= '0;
      endcase
    end
  end

  always_comb begin
    unique case (sel_q)
      RGN_RAM:              in_port = ram_q;
      RGN_TAB:              in_port = DW'(tab_q);
      RGN_SHARED, RGN_INCAP: in_port = small_q;
      default:              in_port = '0;
    endcase
  end

  p_reset_r11: assert property (@(posedge clk)
    rst |=> (irq == 1'b0 && in_port == '0 && out_shared == '0 && out_reg == '0))
    else $error("reset state wrong");
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (read_strobe && region == RGN_NONE) |=> in_port == '0)
    else $error("unmapped read not zero");
  p_outonly_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (read_strobe && port_id == OUTREG_ADDR) |=> in_port == '0)
    else $error("output-only port readable");
  p_read_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !read_strobe |=> $stable(in_port)) else $error("read data moved without strobe");
  p_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    !write_strobe |=> ($stable(out_shared) && $stable(out_reg)))
    else $error("register changed without strobe");
  p_ram_we_range_r3: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> port_id[AW-1:MEM_AW] == '0) else $error("RAM write outside its range");
endmodule

// File: tb/pio_port_hub_bench.sv
module pio_port_hub_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] port_id = '0, out_port = '0, ext_data = '0;
  logic       write_strobe = 1'b0, read_strobe = 1'b0;
  logic       interrupt_ack = 1'b0, ext_event = 1'b0;
  logic [7:0] in_port, out_shared, out_reg;
  logic       irq;

  int errors = 0;
  int checks = 0;
  logic [7:0] ram_m [64];
  logic [7:0] shared_m = '0, outreg_m = '0, ext_m = '0;

  always #5 clk = ~clk;

  pio_port_hub u_pio_port_hub (
    .clk(clk), .rst(rst), .port_id(port_id), .out_port(out_port),
    .write_strobe(write_strobe), .read_strobe(read_strobe),
    .interrupt_ack(interrupt_ack), .ext_event(ext_event), .ext_data(ext_data),
    .in_port(in_port), .out_shared(out_shared), .out_reg(out_reg), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] a);
    if (a < 8'h40)       return ram_m[a[5:0]];
    else if (a < 8'h80)  return a ^ 8'hA5;
    else if (a == 8'h80) return shared_m;
    else if (a == 8'hCF) return ext_m;
    else                 return 8'h00;
  endfunction

  function automatic string tag(input logic [7:0] a);
    if (a < 8'h40)       return "R1";
    else if (a < 8'h80)  return "R2/R3";
    else if (a == 8'h80) return "R4";
    else if (a == 8'hC0) return "R5";
    else if (a == 8'hCF) return "R6";
    else                 return "R7";
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    port_id = a; out_port = d; write_strobe = 1'b1;
    @(negedge clk);
    write_strobe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [7:0] exp);
    @(negedge clk);
    port_id = a; read_strobe = 1'b1;
    @(negedge clk);
    read_strobe = 1'b0;
    chk(req, in_port, exp);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 irq", {7'b0, irq}, 8'h00);
    chk("R11 in_port", in_port, 8'h00);
    chk("R11 out_shared", out_shared, 8'h00);
    chk("R11 out_reg", out_reg, 8'h00);

    // R1 fill RAM
    for (int i = 0; i < 64; i++) begin
      ram_m[i] = 8'((i * 7 + 3) ^ 8'h5A);
      wr(8'(i), ram_m[i]);
    end
    // R3 / R7 / R6 writes that must have no effect
    for (int a = 64; a < 256; a++)
      if (a != 8'h80 && a != 8'hC0) wr(8'(a), 8'hEE);
    wr(8'h80, 8'h3C); shared_m = 8'h3C;
    wr(8'hC0, 8'h96); outreg_m = 8'h96;
    @(negedge clk); ext_data = 8'h6B; ext_m = 8'h6B;
    @(negedge clk);

    // Full read sweep over every port (R1..R7)
    for (int a = 0; a < 256; a++) rd(8'(a), tag(8'(a)), model(8'(a)));
    chk("R4 out_shared", out_shared, shared_m);
    chk("R5 out_reg", out_reg, outreg_m);

    // R8: matching port and data without strobe
    @(negedge clk);
    port_id = 8'h80; out_port = 8'h01;
    @(negedge clk); port_id = 8'hC0;
    @(negedge clk); port_id = 8'h10;
    @(negedge clk);
    chk("R8 out_shared", out_shared, shared_m);
    chk("R8 out_reg", out_reg, outreg_m);
    rd(8'h10, "R8 ram", ram_m[16]);

    // R4 back-to-back write then read of shared port
    wr(8'h80, 8'hA7); shared_m = 8'hA7;
    rd(8'h80, "R4 immediate", 8'hA7);
    chk("R4 out_shared", out_shared, 8'hA7);

    // R9 latency and hold
    rd(8'h05, "R9 first", ram_m[5]);
    @(negedge clk);
    port_id = 8'h06; read_strobe = 1'b1;
    #4 chk("R9 before edge", in_port, ram_m[5]);
    @(negedge clk);
    read_strobe = 1'b0;
    chk("R9 after edge", in_port, ram_m[6]);
    port_id = 8'h45;
    repeat (3) @(negedge clk);
    chk("R9 hold", in_port, ram_m[6]);

    // R6 new external byte
    @(negedge clk); ext_data = 8'hC4; ext_m = 8'hC4;
    @(negedge clk);
    rd(8'hCF, "R6 capture", 8'hC4);

    // R10 interrupt latch
    @(negedge clk); ext_event = 1'b1;
    @(negedge clk); ext_event = 1'b0;
    chk("R10 set", {7'b0, irq}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R10 held", {7'b0, irq}, 8'h01);
    interrupt_ack = 1'b1;
    @(negedge clk); interrupt_ack = 1'b0;
    chk("R10 cleared", {7'b0, irq}, 8'h00);
    ext_event = 1'b1; interrupt_ack = 1'b1;
    @(negedge clk); ext_event = 1'b0; interrupt_ack = 1'b0;
    chk("R10 set wins", {7'b0, irq}, 8'h01);
    interrupt_ack = 1'b1;
    @(negedge clk); interrupt_ack = 1'b0;
    chk("R10 ack alone", {7'b0, irq}, 8'h00);

    // R11 reset again clears registers
    @(negedge clk); ext_event = 1'b1;
    @(negedge clk); ext_event = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R11 irq after", {7'b0, irq}, 8'h00);
    chk("R11 out_shared after", out_shared, 8'h00);
    chk("R11 out_reg after", out_reg, 8'h00);
    chk("R11 in_port after", in_port, 8'h00);
    summary();
  end
endmodule